// File: doc/BRIEF.md
# I2C Slave Address Matcher with Per-Bit Mask

This block is the address-phase front end of an I2C target. It watches the SCL and SDA lines using a system clock that runs much faster than SCL. It finds START, repeated START and STOP conditions and shifts in address bytes MSB first. Each byte is compared against a programmable own-address through a per-bit mask, and the block pulls SDA low in the ninth clock when the comparison passes. A mask bit of zero turns the matching received bit into a don't-care, so one target can answer a whole family of addresses.

Two address formats are supported, chosen by a mode input. In 7-bit mode the first byte carries the address in bits 7:1 and the read/write flag in bit 0. In 10-bit mode a header byte of the form 11110-A9-A8-R/W is acknowledged first. It is always compared exactly against a separate two-bit high-address register. The low address byte is then compared through the full eight-bit mask. The own-address, mask and high-address registers are loaded through a small parallel write port. A write lands at once but is only used from the next START (or repeated START), so an address phase already under way keeps the values it started with. The block reports a one-cycle match pulse, the read/write flag of the accepted header and a bus-busy flag.

Top module: `i2cm_addr_match`

## Requirements
- R1: After reset, sda_oe, busy and match_pulse are 0, and the mask register holds all ones, so an address that differs from the own-address in any compared bit is not acknowledged.
- R2: busy goes to 1 after a START (SDA falling while SCL is high) and returns to 0 after a STOP (SDA rising while SCL is high).
- R3: In 7-bit mode (mode_10b = 0), received bits 7:1 are compared with own-address bits 7:1 wherever the mask bit is 1, and the bits where the mask is 0 are ignored. On a pass, sda_oe is 1 during the ninth SCL clock and match_pulse fires once, just after that clock ends.
- R4: In 7-bit mode, received bit 0 (R/W), own-address bit 0 and mask bit 0 have no effect on the decision.
- R5: On a failed compare, sda_oe stays 0, no match_pulse is produced, and later bytes are ignored until the next START.
- R6: In 10-bit mode (mode_10b = 1), the first byte passes only if bits 7:3 equal 11110 and bits 2:1 equal the high-address register. The mask has no effect on this byte. A passing header is acknowledged without a match_pulse.
- R7: In 10-bit mode, the second byte is compared over bits 7:0 through the mask, including bit 0. When it passes, it is acknowledged and match_pulse fires once after its ninth clock.
- R8: A repeated START abandons the current address phase, including an ignored one, and starts a fresh one.
- R9: Writes through the write port (wr_sel 0 = own-address, 1 = mask, 2 = high-address in bits 1:0, 3 = no register), and the value of mode_10b, are used only from the next START or repeated START.
- R10: rw_bit takes bit 0 of the first address byte whenever that byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, the open-drain driver pulls SDA low |
| mode_10b | input | 1 | 0 = 7-bit addressing, 1 = 10-bit addressing |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 own-address, 1 mask, 2 high-address |
| wr_data | input | 8 | Register write data |
| match_pulse | output | 1 | One-cycle pulse after a fully matched address is acknowledged |
| rw_bit | output | 1 | R/W bit of the last acknowledged first address byte |
| busy | output | 1 | Bus is between a START and a STOP |

## Verification
The hardest situation to reach is a register write that lands while an address phase is running, because the frozen copy is only visible through later ACK decisions. The bench writes a new own-address right after a START. It then sends the old address and expects an ACK, issues a repeated START, and expects the old address to be refused and the new one accepted. Ignored traffic after a mismatch is reached the same way: a correctly addressed byte is clocked in without a START, and the bench checks that no ACK appears.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int unsigned ADDR_BITS = 8;
    localparam int unsigned CNT_W     = $clog2(ADDR_BITS + 1);
    localparam int unsigned HI_W      = 2;

    typedef logic [ADDR_BITS-1:0] abyte_t;

    // Register select codes for the write port
    localparam logic [1:0] SEL_OWN  = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_HI   = 2'd2;

    // Fixed prefix of a 10-bit header byte, bits 7:3
    localparam logic [4:0] HDR_TAG = 5'b11110;

    typedef struct packed {
        abyte_t          own;
        abyte_t          mask;
        logic [HI_W-1:0] hi;
        logic            ten_bit;
    } cfg_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_HOLD,
        ST_SKIP
    } phase_t;

    function automatic logic masked_eq(abyte_t rx, abyte_t ref_v, abyte_t msk);
        return ((rx ^ ref_v) & msk) == '0;
    endfunction

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync
    import i2cm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_q, sda_q;
    logic scl_d, sda_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_i;
                    sda_q <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
                    sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q[LAST];
            sda_d <= sda_q[LAST];
        end
    end

    always_comb begin
        ev.scl      = scl_q[LAST];
        ev.sda      = sda_q[LAST];
        ev.scl_rise = scl_q[LAST] & ~scl_d;
        ev.scl_fall = ~scl_q[LAST] & scl_d;
        ev.start    = scl_q[LAST] & scl_d & sda_d & ~sda_q[LAST];
        ev.stop     = scl_q[LAST] & scl_d & ~sda_d & sda_q[LAST];
    end

    AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop)); // R2

endmodule

// File: rtl/i2cm_cfg_regs.sv
module i2cm_cfg_regs
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  abyte_t     wr_data,
    input  logic       mode_10b,
    input  logic       load,
    output cfg_t       active
);
    cfg_t live;

    always_ff @(posedge clk) begin
        if (rst) begin
            live.own     <= '0;
            live.mask    <= '1;
            live.hi      <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_OWN:  live.own  <= wr_data;
                SEL_MASK: live.mask <= wr_data;
                SEL_HI:   live.hi   <= wr_data[HI_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb live.ten_bit = mode_10b;

    always_ff @(posedge clk) begin
        if (rst) begin
            active.own     <= '0;
            active.mask    <= '1;
            active.hi      <= '0;
            active.ten_bit <= 1'b0;
        end else if (load) begin
            active <= live;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active)); // R9

endmodule

// File: rtl/i2cm_addr_cmp.sv
module i2cm_addr_cmp
    import i2cm_pkg::*;
(
    input  abyte_t rx,
    input  cfg_t   cfg,
    input  logic   second,
    output logic   hit
);
    logic hdr_ok, low_ok, short_ok;

    always_comb begin
        hdr_ok   = (rx[7:3] == HDR_TAG) && (rx[2:1] == cfg.hi);
        low_ok   = masked_eq(rx, cfg.own, cfg.mask);
        short_ok = masked_eq(rx, cfg.own, {cfg.mask[ADDR_BITS-1:1], 1'b0});
        if (cfg.ten_bit) hit = second ? low_ok : hdr_ok;
        else             hit = short_ok;
    end

endmodule

// File: rtl/i2cm_addr_match.sv
module i2cm_addr_match
    import i2cm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       mode_10b,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic       match_pulse,
    output logic       rw_bit,
    output logic       busy
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BITS);

    bus_ev_t          ev;
    cfg_t             cfg;
    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    abyte_t           shreg;
    logic             second;
    logic             hit;

    i2cm_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cm_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .mode_10b (mode_10b),
        .load     (ev.start),
        .active   (cfg)
    );

    i2cm_addr_cmp u_cmp (
        .rx     (shreg),
        .cfg    (cfg),
        .second (second),
        .hit    (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= ST_IDLE;
            cnt         <= '0;
            shreg       <= '0;
            second      <= 1'b0;
            sda_oe      <= 1'b0;
            match_pulse <= 1'b0;
            rw_bit      <= 1'b0;
            busy        <= 1'b0;
        end else begin
            match_pulse <= 1'b0;
            if (ev.start) begin
                phase  <= ST_ADDR;
                cnt    <= '0;
                second <= 1'b0;
                sda_oe <= 1'b0;
                busy   <= 1'b1;
            end else if (ev.stop) begin
                phase  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
                busy   <= 1'b0;
            end else begin
                case (phase)
                    ST_ADDR: begin
                        if (ev.scl_rise && cnt != FULL) begin
                            shreg <= {shreg[ADDR_BITS-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == FULL) begin
                            if (hit) begin
                                sda_oe <= 1'b1;
                                phase  <= ST_ACK;
                                if (!second) rw_bit <= shreg[0];
                            end else begin
                                phase <= ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            if (cfg.ten_bit && !second) begin
                                second <= 1'b1;
                                phase  <= ST_ADDR;
                            end else begin
                                match_pulse <= 1'b1;
                                phase       <= ST_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_QUIET_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sda_oe); // R2
    AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !busy); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        match_pulse |=> !match_pulse); // R3
    AST_PULSE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(match_pulse) |-> $past(sda_oe)); // R7
    AST_NO_PULSE_ON_HDR: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> (second || !cfg.ten_bit)); // R6
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_SKIP) |-> !sda_oe); // R5

endmodule

// File: tb/i2cm_addr_match_bench.sv
module i2cm_addr_match_bench;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, match_pulse, rw_bit, busy;
    logic mode_10b = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic sda_line;
    int vectors = 0, miscompares = 0, pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2cm_addr_match u_i2cm_addr_match (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .mode_10b(mode_10b), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .match_pulse(match_pulse), .rw_bit(rw_bit), .busy(busy)
    );

    always @(posedge clk) if (!rst && match_pulse) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic cond_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic cond_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output int np);
        int p0;
        p0 = pulses;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = sda_oe;
        scl_m = 1'b0; wq();
        np = pulses - p0;
    endtask

    task automatic t_reset();
        logic a; int n;
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 match_pulse", match_pulse, 0);
        wr(2'd0, 8'h54);
        cond_start();
        send_byte(8'h56, a, n);
        chk("R1 bit1 compared after reset", a, 0);
        cond_stop();
    endtask

    task automatic t_7bit();
        logic a; int n;
        cond_start();
        chk("R2 busy after start", busy, 1);
        send_byte(8'h55, a, n);
        chk("R3 ack exact", a, 1);
        chk("R3 one pulse", n, 1);
        chk("R10 rw read", rw_bit, 1);
        chk("R4 bit0 not compared", a, 1);
        cond_stop();
        chk("R2 busy after stop", busy, 0);
        wr(2'd1, 8'hF0);
        cond_start();
        send_byte(8'h5A, a, n);
        chk("R3 masked bits ignored", a, 1);
        chk("R10 rw write", rw_bit, 0);
        cond_stop();
        wr(2'd0, 8'h55);
        wr(2'd1, 8'hFE);
        cond_start();
        send_byte(8'h54, a, n);
        chk("R4 own bit0 and mask bit0 ignored", a, 1);
        cond_stop();
    endtask

    task automatic t_mismatch();
        logic a; int n;
        wr(2'd0, 8'h54);
        wr(2'd1, 8'hF0);
        cond_start();
        send_byte(8'h74, a, n);
        chk("R5 no ack", a, 0);
        chk("R5 no pulse", n, 0);
        send_byte(8'h54, a, n);
        chk("R5 ignored until start", a, 0);
        chk("R5 still busy", busy, 1);
        cond_stop();
    endtask

    task automatic t_10bit();
        logic a; int n;
        mode_10b = 1'b1;
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'hFF);
        cond_start();
        send_byte(8'hF4, a, n);
        chk("R6 header ack", a, 1);
        chk("R6 header no pulse", n, 0);
        send_byte(8'h3C, a, n);
        chk("R7 low byte ack", a, 1);
        chk("R7 low byte pulse", n, 1);
        chk("R10 rw from header", rw_bit, 0);
        cond_stop();
        wr(2'd1, 8'h00);
        cond_start();
        send_byte(8'hF2, a, n);
        chk("R6 mask no effect on header", a, 0);
        cond_stop();
        cond_start();
        send_byte(8'hF5, a, n);
        chk("R6 header ack rw1", a, 1);
        send_byte(8'hC3, a, n);
        chk("R7 fully masked low byte", a, 1);
        cond_stop();
        wr(2'd1, 8'h01);
        cond_start();
        send_byte(8'hF4, a, n);
        send_byte(8'h3D, a, n);
        chk("R7 bit0 compared in 10-bit", a, 0);
        chk("R7 no pulse on fail", n, 0);
        cond_stop();
        mode_10b = 1'b0;
    endtask

    task automatic t_restart();
        logic a; int n;
        wr(2'd0, 8'h54);
        wr(2'd1, 8'hFF);
        cond_start();
        send_byte(8'h20, a, n);
        chk("R8 first refused", a, 0);
        cond_start();
        send_byte(8'h54, a, n);
        chk("R8 ack after repeated start", a, 1);
        chk("R8 pulse after repeated start", n, 1);
        cond_stop();
    endtask

    task automatic t_late_write();
        logic a; int n;
        wr(2'd0, 8'h54);
        cond_start();
        wr(2'd0, 8'h60);
        send_byte(8'h54, a, n);
        chk("R9 old address kept", a, 1);
        cond_start();
        send_byte(8'h54, a, n);
        chk("R9 old address dropped", a, 0);
        cond_start();
        send_byte(8'h60, a, n);
        chk("R9 new address used", a, 1);
        cond_stop();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_7bit();
        t_mismatch();
        t_10bit();
        t_restart();
        t_late_write();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule